// File: doc/BRIEF.md
# Contact Card Activation Sequencer

This block drives the supply, reset, clock and I/O lines of a contact smart card through power-up, cold reset, the answer-to-reset window, warm reset and power-down. A divider outside the block supplies a one-cycle strobe on every card-clock rising edge. Every delay is counted in those strobes, so the timing holds at any divider setting. A UART receiver outside the block supplies received characters and their parity status. The sequencer inspects only the first two characters of the answer. It takes the coding convention from the first character and reports the active state once the second has arrived cleanly.

Host software issues activate, deactivate and warm-reset requests. It reads progress from a one-hot state code and a one-cycle entry strobe. The entry strobe lets interrupt logic qualify entry into each state on its own. The block powers the card down by itself in three cases: the card is pulled, the supply drops out, or the card never starts its answer.

Top module: `card_seq`

## Requirements
- R1: After reset the state code is power-off (0x01), with power enable low, card reset low, I/O forced low and card clock disabled. The state code is always one-hot: activation-timeout 0x02, deactivation 0x04, waiting-for-power 0x08, activation/reset 0x10, waiting-for-TS 0x20, waiting-for-T0 0x40, active 0x80.
- R2: An activate request is honoured only in power-off with a card present. It raises power enable and enters waiting-for-power. Power good then enables the card clock, releases I/O and enters activation/reset with card reset low.
- R3: Card reset stays low for RST_LOW_CLKS (40000) card-clock strobes counted from entry into activation/reset. It rises in the same cycle that waiting-for-TS is entered.
- R4: A low I/O level within the first EARLY_CLKS (380) strobes of waiting-for-TS sets the early-answer flag. Characters received inside that window are ignored. The flag clears when reset is next driven low.
- R5: If no start bit (I/O low after the early window) is seen within TS_LIMIT_CLKS (42001) strobes of waiting-for-TS, the block spends exactly one cycle in activation-timeout and then enters deactivation.
- R6: Deactivation drives card reset low at once. It disables the clock after 16 strobes, forces I/O low after 32 and drops power enable after 48, returning to power-off.
- R7: An error-free first character of 0x3B sets direct convention (inverse flag 0) and 0x3F sets inverse convention (inverse flag 1). Either value also sets the convention-known flag and moves to waiting-for-T0. Any other value goes to deactivation when the bad-TS option input is high. Otherwise it goes to waiting-for-T0 with convention-known low.
- R8: In waiting-for-TS and waiting-for-T0, a character flagged with a parity error is ignored. An error-free character in waiting-for-T0 enters active.
- R9: A warm-reset request is honoured only in active. It enters activation/reset with card reset low while clock and I/O stay on, then follows R3 back to waiting-for-TS. It has no effect in any other state.
- R10: With test mode high, the reset-low time uses only the low 8 bits of RST_LOW_CLKS (64 strobes by default).
- R11: A deactivate request, loss of card present, or loss of power good (once activation/reset has been reached) moves any state other than power-off, deactivation and activation-timeout to deactivation on the next cycle. In power-off a deactivate request has no effect.
- R12: The entry strobe is high for exactly the first cycle of each new state, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_mode_i | input | 1 | Shortens the reset-low time |
| cclk_rise_i | input | 1 | Card-clock rising-edge strobe |
| card_present_i | input | 1 | Card present switch |
| pwr_good_i | input | 1 | Card supply within range |
| io_level_i | input | 1 | Card I/O line level |
| act_req_i | input | 1 | Activate request |
| deact_req_i | input | 1 | Deactivate request |
| warm_req_i | input | 1 | Warm-reset request |
| bad_ts_deact_i | input | 1 | Deactivate on an unknown first character |
| rx_valid_i | input | 1 | Character received strobe |
| rx_err_i | input | 1 | Received character has a parity error |
| rx_data_i | input | 8 | Received character |
| vcc_en_o | output | 1 | Card power enable |
| card_rst_o | output | 1 | Card reset line |
| io_low_o | output | 1 | Force card I/O low |
| clk_en_o | output | 1 | Card clock enable |
| state_o | output | 8 | One-hot state code |
| entry_o | output | 1 | First cycle of a new state |
| conv_inv_o | output | 1 | Inverse convention selected |
| conv_known_o | output | 1 | Convention taken from the first character |
| early_o | output | 1 | Early answer seen |

## Verification
The sequence is run twice for each strobe pattern: once with a strobe every cycle and once with randomly gapped strobes. A block that counts system cycles instead of card clocks therefore fails the reset-low and deactivation spacing. First characters 0x3B, 0x3F and an unknown value, with the option both on and off, tell the two conventions apart from the reject path. Characters sent inside and after the early window, and a clean character versus a parity-flagged one, show that the window and error gating take effect. Random abort kinds at random points of activation check that each abort path reaches deactivation in one cycle.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  typedef enum logic [7:0] {
    ST_OFF     = 8'h01,
    ST_TIMEOUT = 8'h02,
    ST_DEACT   = 8'h04,
    ST_WAITPWR = 8'h08,
    ST_ACTRST  = 8'h10,
    ST_WAITTS  = 8'h20,
    ST_WAITT0  = 8'h40,
    ST_ACTIVE  = 8'h80
  } seq_state_e;

  function automatic int unsigned cnt_bits(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/card_seq_cnt.sv
module card_seq_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);

  // saturating card-clock counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_o <= '0;
    else if (clr_i)                           cnt_o <= '0;
    else if (tick_i && (cnt_o != {W{1'b1}}))  cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/card_seq_tsdec.sv
module card_seq_tsdec #(
  parameter logic [7:0] DIRECT_CODE  = 8'h3B,
  parameter logic [7:0] INVERSE_CODE = 8'h3F
) (
  input  logic [7:0] data_i,
  output logic       direct_o,
  output logic       inverse_o
);

  assign direct_o  = (data_i == DIRECT_CODE);
  assign inverse_o = (data_i == INVERSE_CODE);

endmodule

// File: rtl/card_seq.sv
module card_seq
  import card_seq_pkg::*;
#(
  parameter int unsigned RST_LOW_CLKS   = 40000,
  parameter int unsigned EARLY_CLKS     = 380,
  parameter int unsigned TS_LIMIT_CLKS  = 42001,
  parameter int unsigned STEP_CLKS      = 16,
  parameter int unsigned TEST_KEEP_BITS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       test_mode_i,
  input  logic       cclk_rise_i,
  input  logic       card_present_i,
  input  logic       pwr_good_i,
  input  logic       io_level_i,
  input  logic       act_req_i,
  input  logic       deact_req_i,
  input  logic       warm_req_i,
  input  logic       bad_ts_deact_i,
  input  logic       rx_valid_i,
  input  logic       rx_err_i,
  input  logic [7:0] rx_data_i,
  output logic       vcc_en_o,
  output logic       card_rst_o,
  output logic       io_low_o,
  output logic       clk_en_o,
  output logic [7:0] state_o,
  output logic       entry_o,
  output logic       conv_inv_o,
  output logic       conv_known_o,
  output logic       early_o
);

  localparam int unsigned CNT_W = cnt_bits(RST_LOW_CLKS, EARLY_CLKS, TS_LIMIT_CLKS, STEP_CLKS);
  localparam int unsigned TEST_MASK = (1 << TEST_KEEP_BITS) - 1;
  localparam logic [CNT_W-1:0] RST_FULL  = CNT_W'(RST_LOW_CLKS);
  localparam logic [CNT_W-1:0] RST_TEST  = CNT_W'(RST_LOW_CLKS & TEST_MASK);
  localparam logic [CNT_W-1:0] EARLY_LIM = CNT_W'(EARLY_CLKS);
  localparam logic [CNT_W-1:0] TS_LAST   = CNT_W'(TS_LIMIT_CLKS - 1);
  localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(STEP_CLKS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rst_lim;
  logic [1:0]       dphase_q;
  logic             clk_q, io_rel_q, early_q, started_q, inv_q, known_q, entry_q;
  logic             ts_direct, ts_inverse;
  logic             rx_ok, in_early, start_now, step_last, pwr_state, abort, changed, cnt_clr;

  card_seq_tsdec u_tsdec (
    .data_i    (rx_data_i),
    .direct_o  (ts_direct),
    .inverse_o (ts_inverse)
  );

  card_seq_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .tick_i (cclk_rise_i),
    .cnt_o  (cnt)
  );

  assign rst_lim   = test_mode_i ? RST_TEST : RST_FULL;
  assign rx_ok     = rx_valid_i && !rx_err_i;
  assign in_early  = cnt < EARLY_LIM;
  assign start_now = !io_level_i && !in_early;
  assign step_last = cclk_rise_i && (cnt == STEP_LAST);
  assign pwr_state = (state_q == ST_ACTRST) || (state_q == ST_WAITTS) ||
                     (state_q == ST_WAITT0) || (state_q == ST_ACTIVE);
  assign abort     = (state_q != ST_OFF) && (state_q != ST_DEACT) && (state_q != ST_TIMEOUT) &&
                     (deact_req_i || !card_present_i || (pwr_state && !pwr_good_i));

  always_comb begin
    state_d = state_q;
    if (abort) begin
      state_d = ST_DEACT;
    end else begin
      unique case (state_q)
        ST_OFF:     if (act_req_i && card_present_i) state_d = ST_WAITPWR;
        ST_WAITPWR: if (pwr_good_i) state_d = ST_ACTRST;
        ST_ACTRST:  if (cclk_rise_i && (cnt == rst_lim - 1'b1)) state_d = ST_WAITTS;
        ST_WAITTS: begin
          if (rx_ok && started_q) begin
            if (ts_direct || ts_inverse || !bad_ts_deact_i) state_d = ST_WAITT0;
            else                                            state_d = ST_DEACT;
          end else if (cclk_rise_i && (cnt == TS_LAST) && !started_q && !start_now) begin
            state_d = ST_TIMEOUT;
          end
        end
        ST_WAITT0:  if (rx_ok) state_d = ST_ACTIVE;
        ST_ACTIVE:  if (warm_req_i) state_d = ST_ACTRST;
        ST_TIMEOUT: state_d = ST_DEACT;
        ST_DEACT:   if (step_last && (dphase_q == 2'd2)) state_d = ST_OFF;
        default:    state_d = ST_OFF;
      endcase
    end
  end

  assign changed = (state_d != state_q);
  assign cnt_clr = changed || ((state_q == ST_DEACT) && step_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OFF;
      entry_q   <= 1'b0;
      dphase_q  <= '0;
      clk_q     <= 1'b0;
      io_rel_q  <= 1'b0;
      early_q   <= 1'b0;
      started_q <= 1'b0;
      inv_q     <= 1'b0;
      known_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      entry_q <= changed;
      if ((state_q == ST_WAITPWR) && (state_d == ST_ACTRST)) begin
        clk_q    <= 1'b1;
        io_rel_q <= 1'b1;
      end
      if (changed && (state_d == ST_ACTRST)) begin
        early_q <= 1'b0;
        known_q <= 1'b0;
      end
      if (changed && (state_d == ST_WAITTS)) started_q <= 1'b0;
      else if ((state_q == ST_WAITTS) && start_now) started_q <= 1'b1;
      if ((state_q == ST_WAITTS) && !io_level_i && in_early) early_q <= 1'b1;
      if ((state_q == ST_WAITTS) && (state_d == ST_WAITT0)) begin
        known_q <= ts_direct || ts_inverse;
        if (ts_inverse)     inv_q <= 1'b1;
        else if (ts_direct) inv_q <= 1'b0;
      end
      // deactivation steps: clock off, then I/O low, then power off
      if (changed && (state_d == ST_DEACT)) begin
        dphase_q <= '0;
      end else if ((state_q == ST_DEACT) && step_last) begin
        dphase_q <= dphase_q + 1'b1;
        if (dphase_q == 2'd0) clk_q    <= 1'b0;
        if (dphase_q == 2'd1) io_rel_q <= 1'b0;
      end
    end
  end

  assign vcc_en_o     = (state_q != ST_OFF);
  assign card_rst_o   = (state_q == ST_WAITTS) || (state_q == ST_WAITT0) ||
                        (state_q == ST_ACTIVE) || (state_q == ST_TIMEOUT);
  assign io_low_o     = !io_rel_q;
  assign clk_en_o     = clk_q;
  assign state_o      = state_q;
  assign entry_o      = entry_q;
  assign conv_inv_o   = inv_q;
  assign conv_known_o = known_q;
  assign early_o      = early_q;

endmodule

// File: rtl/card_seq_chk.sv
module card_seq_chk
  import card_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       card_present_i,
  input logic       pwr_good_i,
  input logic       deact_req_i,
  input logic       warm_req_i,
  input logic       vcc_en_o,
  input logic       card_rst_o,
  input logic       io_low_o,
  input logic       clk_en_o,
  input logic [7:0] state_o,
  input logic       entry_o
);

  logic live;
  assign live = (state_o != ST_OFF) && (state_o != ST_DEACT) && (state_o != ST_TIMEOUT);

  AST_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_o) == 1); // R1
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_OFF |-> !vcc_en_o && !card_rst_o && io_low_o && !clk_en_o); // R1
  AST_RST_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_rst_o) |-> state_o == ST_WAITTS && entry_o); // R3
  AST_TIMEOUT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_TIMEOUT |=> state_o == ST_DEACT); // R5
  AST_PWR_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vcc_en_o) |-> !clk_en_o && io_low_o && !card_rst_o); // R6
  AST_IO_AFTER_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_low_o) |-> !clk_en_o && !card_rst_o); // R6
  AST_WARM_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_ACTIVE && warm_req_i && !deact_req_i && card_present_i && pwr_good_i
      |=> state_o == ST_ACTRST); // R9
  AST_CARD_PULLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live && !card_present_i |=> state_o == ST_DEACT); // R11
  AST_ENTRY_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(state_o) |-> entry_o); // R12
  AST_ENTRY_ONLY_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> !$stable(state_o)); // R12

endmodule

bind card_seq card_seq_chk u_card_seq_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .card_present_i (card_present_i),
  .pwr_good_i     (pwr_good_i),
  .deact_req_i    (deact_req_i),
  .warm_req_i     (warm_req_i),
  .vcc_en_o       (vcc_en_o),
  .card_rst_o     (card_rst_o),
  .io_low_o       (io_low_o),
  .clk_en_o       (clk_en_o),
  .state_o        (state_o),
  .entry_o        (entry_o)
);

// File: tb/card_seq_test.sv
module card_seq_test;

  localparam logic [7:0] S_OFF = 8'h01, S_TMO = 8'h02, S_DEACT = 8'h04, S_WPWR = 8'h08;
  localparam logic [7:0] S_RST = 8'h10, S_TS = 8'h20, S_T0 = 8'h40, S_ACT = 8'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b1, cclk_rise = 1'b0, present = 1'b1, pwr_good = 1'b0, io_lvl = 1'b1;
  logic act_req = 1'b0, deact_req = 1'b0, warm_req = 1'b0, bad_opt = 1'b0;
  logic rx_valid = 1'b0, rx_err = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic vcc_en, card_rst, io_low, clk_en, entry, conv_inv, conv_known, early;
  logic [7:0] state;

  int n_chk = 0, n_fail = 0;
  bit full = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  card_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .test_mode_i(test_mode), .cclk_rise_i(cclk_rise),
    .card_present_i(present), .pwr_good_i(pwr_good), .io_level_i(io_lvl),
    .act_req_i(act_req), .deact_req_i(deact_req), .warm_req_i(warm_req),
    .bad_ts_deact_i(bad_opt), .rx_valid_i(rx_valid), .rx_err_i(rx_err), .rx_data_i(rx_data),
    .vcc_en_o(vcc_en), .card_rst_o(card_rst), .io_low_o(io_low), .clk_en_o(clk_en),
    .state_o(state), .entry_o(entry), .conv_inv_o(conv_inv), .conv_known_o(conv_known),
    .early_o(early)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rst_expect(input logic tm);
    return tm ? (40000 & 255) : 40000;
  endfunction

  // card-clock strobe: every cycle or randomly gapped
  always @(posedge clk) begin
    #1;
    cclk_rise = full ? 1'b1 : 1'(($urandom % 2));
  end

  // monitor: strobe counts between state changes
  logic [7:0] prev = S_OFF;
  bit s_prev = 1'b0, prev_clk = 1'b0, prev_iol = 1'b1;
  int scnt = 0, ccyc = 0, dcnt = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit s_app;
      s_app = s_prev;
      s_prev = cclk_rise;
      scnt += int'(s_app);
      ccyc++;
      if (prev == S_DEACT) dcnt += int'(s_app);
      if (state != prev) begin
        check(entry == 1'b1, "R12 entry on change", int'(entry), 1);
        if (prev == S_RST && state == S_TS)
          check(scnt == rst_expect(test_mode), test_mode ? "R10 test reset low" : "R3 reset low",
                scnt, rst_expect(test_mode));
        if (prev == S_TS && state == S_TMO)
          check(scnt == 42001, "R5 TS timeout", scnt, 42001);
        if (prev == S_TMO)
          check(ccyc == 1 && state == S_DEACT, "R5 timeout one cycle", ccyc, 1);
        if (prev == S_DEACT)
          check(dcnt == 48 && state == S_OFF, "R6 power off step", dcnt, 48);
        if (state == S_DEACT) begin
          check(!card_rst && vcc_en, "R6 reset low first", int'(card_rst), 0);
          dcnt = 0;
        end
        scnt = 0;
        ccyc = 0;
      end else begin
        check(entry == 1'b0, "R12 no entry", int'(entry), 0);
      end
      if (state == S_DEACT && prev == S_DEACT) begin
        if (prev_clk && !clk_en) check(dcnt == 16, "R6 clock off step", dcnt, 16);
        if (!prev_iol && io_low) check(dcnt == 32, "R6 io low step", dcnt, 32);
      end
      prev_clk = clk_en;
      prev_iol = io_low;
      prev = state;
    end
  end

  task automatic pulse(input int which);
    @(posedge clk); #1;
    case (which)
      0: act_req = 1'b1;
      1: deact_req = 1'b1;
      default: warm_req = 1'b1;
    endcase
    @(posedge clk); #1;
    act_req = 1'b0; deact_req = 1'b0; warm_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic e);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_data = d; rx_err = e;
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_err = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_bit();
    @(posedge clk); #1 io_lvl = 1'b0;
    @(posedge clk); @(posedge clk); #1 io_lvl = 1'b1;
  endtask

  task automatic wait_state(input logic [7:0] s);
    do @(negedge clk); while (state != s);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic activate();
    pulse(0);
    check(state == S_WPWR && vcc_en && !clk_en && io_low && !card_rst, "R2 waiting for power",
          int'(state), int'(S_WPWR));
    @(posedge clk); #1 pwr_good = 1'b1;
    @(posedge clk); @(negedge clk);
    check(state == S_RST && clk_en && !io_low && !card_rst, "R2 power good starts clock",
          int'(state), int'(S_RST));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7816));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(state == S_OFF && !vcc_en && !card_rst && io_low && !clk_en && !entry,
          "R1 reset state", int'(state), int'(S_OFF));

    pulse(1);
    check(state == S_OFF, "R11 deact ignored in power-off", int'(state), int'(S_OFF));
    pulse(2);
    check(state == S_OFF, "R9 warm ignored in power-off", int'(state), int'(S_OFF));
    present = 1'b0;
    pulse(0);
    check(state == S_OFF && !vcc_en, "R2 no card no activation", int'(state), int'(S_OFF));
    present = 1'b1;

    // cold start in test mode, gapped strobes
    activate();
    wait_state(S_TS);
    check(card_rst == 1'b1, "R3 reset high in waiting-for-TS", int'(card_rst), 1);
    full = 1'b1;
    idle(10);
    #1 io_lvl = 1'b0;
    idle(3);
    #1 io_lvl = 1'b1;
    send(8'h3B, 1'b0);
    check(state == S_TS, "R4 early character ignored", int'(state), int'(S_TS));
    check(early == 1'b1, "R4 early flag set", int'(early), 1);
    idle(400);
    start_bit();
    send(8'h3F, 1'b1);
    check(state == S_TS, "R8 errored TS ignored", int'(state), int'(S_TS));
    send(8'h3F, 1'b0);
    check(state == S_T0 && conv_inv && conv_known, "R7 inverse convention",
          int'(conv_inv), 1);
    pulse(2);
    check(state == S_T0, "R9 warm ignored in waiting-for-T0", int'(state), int'(S_T0));
    send(8'h11, 1'b1);
    check(state == S_T0, "R8 errored T0 ignored", int'(state), int'(S_T0));
    send(8'h11, 1'b0);
    check(state == S_ACT, "R8 T0 completes activation", int'(state), int'(S_ACT));

    // warm reset, full length
    test_mode = 1'b0;
    pulse(2);
    check(state == S_RST && !card_rst && clk_en && !io_low, "R9 warm reset taken",
          int'(state), int'(S_RST));
    wait_state(S_TS);
    check(early == 1'b0, "R4 no early flag", int'(early), 0);
    idle(400);
    start_bit();
    send(8'h3B, 1'b0);
    check(state == S_T0 && !conv_inv && conv_known, "R7 direct convention",
          int'(conv_inv), 0);
    send(8'h00, 1'b0);
    check(state == S_ACT, "R8 active again", int'(state), int'(S_ACT));
    test_mode = 1'b1;

    full = 1'b0;
    pulse(1);
    check(state == S_DEACT, "R11 deact request", int'(state), int'(S_DEACT));
    wait_state(S_OFF);
    check(!vcc_en && io_low && !clk_en && !card_rst, "R6 all off", int'(vcc_en), 0);
    pwr_good = 1'b0;

    // no answer at all
    full = 1'b1;
    activate();
    wait_state(S_TS);
    wait_state(S_TMO);
    check(card_rst == 1'b1, "R5 timeout state", int'(card_rst), 1);
    wait_state(S_OFF);
    pwr_good = 1'b0;

    // unknown TS with option on
    bad_opt = 1'b1;
    activate();
    wait_state(S_TS);
    idle(400);
    start_bit();
    send(8'h55, 1'b0);
    check(state == S_DEACT, "R7 bad TS deactivates", int'(state), int'(S_DEACT));
    wait_state(S_OFF);
    pwr_good = 1'b0;

    // unknown TS with option off, then supply loss
    bad_opt = 1'b0;
    activate();
    wait_state(S_TS);
    idle(400);
    start_bit();
    send(8'h55, 1'b0);
    check(state == S_T0 && !conv_known, "R7 bad TS tolerated", int'(conv_known), 0);
    @(posedge clk); #1 pwr_good = 1'b0;
    @(posedge clk); @(negedge clk);
    check(state == S_DEACT, "R11 power loss", int'(state), int'(S_DEACT));
    wait_state(S_OFF);

    // random abort points and kinds
    full = 1'b0;
    for (int it = 0; it < 8; it++) begin
      int w;
      int k;
      w = $urandom_range(150);
      k = $urandom_range(2);
      activate();
      idle(w);
      #1;
      if (k == 0) deact_req = 1'b1;
      else if (k == 1) present = 1'b0;
      else pwr_good = 1'b0;
      @(posedge clk); #1 deact_req = 1'b0;
      @(negedge clk);
      check(state == S_DEACT, "R11 random abort", int'(state), int'(S_DEACT));
      wait_state(S_OFF);
      present = 1'b1;
      pwr_good = 1'b0;
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule